// File: doc/BRIEF.md
# Interprocessor Interrupt Command Issuer

This block turns register writes into interprocessor interrupt requests for one local interrupt controller. Software writes a command word that holds the vector, delivery type, trigger type, logical/physical destination flag and a destination shorthand. The block decodes these fields and builds a target mask with one bit per unit. It then offers a single delivery request on a valid/ready channel. When the shorthand names an explicit destination, the block asks an external resolver to turn the destination into a mask and waits for the answer.

The block runs in one of two addressing modes, chosen by `ext_mode`. In legacy mode the destination is an 8-bit value, held in the top byte of a separate high command word that is written first. In extended mode a single 64-bit write carries the destination as its upper 32 bits. Extended mode also opens a self-interrupt register: one write to it sends a vector to this unit alone.

The control is a three-state machine:
- `ST_IDLE` accepts writes.
- `ST_RESOLVE` waits for the resolver.
- `ST_SEND` holds the request until it is taken.

Its transitions are:
- IDLE→RESOLVE on a command write with shorthand 0.
- IDLE→SEND on a command write with any other shorthand, or on a self-interrupt write.
- RESOLVE→SEND on `rsv_ack`.
- SEND→IDLE on `dlv_valid && dlv_ready`.

Rejected writes leave the machine in IDLE.

Top module: `ipi_cmd_issuer`

## Requirements
- R1: After reset `dlv_valid`, `rsv_req` and `wr_err` are 0 and `wr_ready` is 1.
- R2: The command word (index 0x30) fields appear on the request:
  - vector in bits 7:0 on `dlv_vector`
  - delivery type in bits 10:8 on `dlv_mode`
  - logical flag in bit 11 on `dlv_logical`
  - level trigger in bit 15 on `dlv_level`
  - shorthand in bits 19:18
- R3: In legacy mode, a command write takes its destination from bits 31:24 of the last high word written to index 0x31. That value is zero-extended onto `rsv_dest`, and `rsv_logical` carries bit 11.
- R4: In extended mode, a command write takes the 32-bit destination from `wr_data[63:32]`.
- R5: Shorthand 0 raises `rsv_req` one cycle after the write and holds it until `rsv_ack`. The request mask is then the `rsv_mask` sampled with `rsv_ack`. The other shorthands never raise `rsv_req`.
- R6: The other shorthands form the mask directly. Shorthand 1 sets only bit `self`. Shorthand 2 sets every bit. Shorthand 3 sets every bit except bit `self`. A `self` value of N_UNITS or above matches no bit.
- R7: `self` is `self_id_ext` (32 bits) in extended mode and `self_id_leg` (8 bits) in legacy mode.
- R8: A write to index 0x31 in extended mode is rejected and does not change the stored high word.
- R9: A write to index 0x3F in extended mode sends `wr_data[7:0]` as the vector, with delivery type 0, edge trigger, physical flag and mask bit `self` only. In legacy mode the same write is rejected.
- R10: Every rejected write, including any index other than 0x30, 0x31 and 0x3F, pulses `wr_err` for the one cycle after the write and raises no request.
- R11: From the cycle after an accepted send until the request is taken, `wr_ready` is 0. During that time the request outputs hold steady while `dlv_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_mode | input | 1 | 1 selects extended addressing |
| self_id_leg | input | 8 | This unit's legacy identifier |
| self_id_ext | input | 32 | This unit's extended identifier |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | IDX_W | Register index |
| wr_data | input | 64 | Write data |
| wr_ready | output | 1 | Block can take a write this cycle |
| wr_err | output | 1 | One-cycle pulse after a rejected write |
| rsv_req | output | 1 | Resolver lookup request |
| rsv_dest | output | 32 | Destination to resolve |
| rsv_logical | output | 1 | Destination is logical |
| rsv_ack | input | 1 | Resolver answer valid |
| rsv_mask | input | N_UNITS | Resolved target mask |
| dlv_valid | output | 1 | Delivery request valid |
| dlv_ready | input | 1 | Delivery request taken |
| dlv_mask | output | N_UNITS | Target units |
| dlv_vector | output | 8 | Interrupt vector |
| dlv_mode | output | 3 | Delivery type |
| dlv_level | output | 1 | Level trigger |
| dlv_logical | output | 1 | Logical destination flag |

## Verification
The hardest case to reach from the ports is a send that depends on stale state. Two examples are a legacy send after a rejected extended-mode high-word write, and a self-target shorthand whose identifier matches no unit. The bench sweeps every shorthand in both modes over identifiers inside the unit range, at its last unit and past it. It gives the two identifier inputs different values each time, so a wrong selection shows in the mask. It then writes a high word in extended mode, drops back to legacy mode and sends. The destination presented to the resolver must still be the earlier legacy high word.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RESOLVE = 2'd1,
        ST_SEND    = 2'd2
    } ipi_state_e;

    localparam logic [1:0] SH_NONE   = 2'd0;
    localparam logic [1:0] SH_SELF   = 2'd1;
    localparam logic [1:0] SH_ALL    = 2'd2;
    localparam logic [1:0] SH_OTHERS = 2'd3;

    localparam int unsigned IDX_CMD_LO = 32'h30;
    localparam int unsigned IDX_CMD_HI = 32'h31;
    localparam int unsigned IDX_SELF   = 32'h3F;

    typedef struct packed {
        logic [7:0] vector;
        logic [2:0] dmode;
        logic       logical;
        logic       level;
        logic [1:0] shorthand;
    } ipi_cmd_t;

endpackage

// File: rtl/ipi_field_decode.sv
module ipi_field_decode
    import ipi_pkg::*;
(
    input  logic [31:0] word,
    output ipi_cmd_t    cmd
);
    always_comb begin
        cmd.vector    = word[7:0];
        cmd.dmode     = word[10:8];
        cmd.logical   = word[11];
        cmd.level     = word[15];
        cmd.shorthand = word[19:18];
    end
endmodule

// File: rtl/ipi_target_mask.sv
module ipi_target_mask
    import ipi_pkg::*;
#(
    parameter int N_UNITS = 8
) (
    input  logic [1:0]         shorthand,
    input  logic [31:0]        self_id,
    output logic [N_UNITS-1:0] mask
);
    logic [N_UNITS-1:0] self_hit;

    for (genvar i = 0; i < N_UNITS; i++) begin : g_hit
        assign self_hit[i] = (self_id == 32'(i));
    end

    always_comb begin
        unique case (shorthand)
            SH_SELF:   mask = self_hit;
            SH_ALL:    mask = '1;
            SH_OTHERS: mask = ~self_hit;
            default:   mask = '0;
        endcase
    end
endmodule

// File: rtl/ipi_cmd_issuer.sv
module ipi_cmd_issuer
    import ipi_pkg::*;
#(
    parameter int N_UNITS = 8,
    parameter int IDX_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_mode,
    input  logic [7:0]         self_id_leg,
    input  logic [31:0]        self_id_ext,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [63:0]        wr_data,
    output logic               wr_ready,
    output logic               wr_err,
    output logic               rsv_req,
    output logic [31:0]        rsv_dest,
    output logic               rsv_logical,
    input  logic               rsv_ack,
    input  logic [N_UNITS-1:0] rsv_mask,
    output logic               dlv_valid,
    input  logic               dlv_ready,
    output logic [N_UNITS-1:0] dlv_mask,
    output logic [7:0]         dlv_vector,
    output logic [2:0]         dlv_mode,
    output logic               dlv_level,
    output logic               dlv_logical
);
    localparam logic [IDX_W-1:0] IX_LO   = IDX_W'(IDX_CMD_LO);
    localparam logic [IDX_W-1:0] IX_HI   = IDX_W'(IDX_CMD_HI);
    localparam logic [IDX_W-1:0] IX_SELF = IDX_W'(IDX_SELF);

    ipi_state_e         state_q, state_d;
    logic [31:0]        hi_q;
    ipi_cmd_t           lo_cmd, new_cmd;
    logic [N_UNITS-1:0] sh_mask;
    logic [31:0]        self_sel, new_dest;
    logic               acc, is_lo, is_hi, is_self, reject, start;

    ipi_field_decode u_dec (
        .word (wr_data[31:0]),
        .cmd  (lo_cmd)
    );

    ipi_target_mask #(.N_UNITS(N_UNITS)) u_mask (
        .shorthand (new_cmd.shorthand),
        .self_id   (self_sel),
        .mask      (sh_mask)
    );

    // write decode
    always_comb begin
        acc      = wr_en && (state_q == ST_IDLE);
        is_lo    = (wr_idx == IX_LO);
        is_hi    = (wr_idx == IX_HI);
        is_self  = (wr_idx == IX_SELF);
        reject   = acc && ((is_hi && ext_mode) || (is_self && !ext_mode) ||
                           !(is_lo || is_hi || is_self));
        start    = acc && !reject && (is_lo || is_self);
        self_sel = ext_mode ? self_id_ext : {24'd0, self_id_leg};
        new_dest = ext_mode ? wr_data[63:32] : {24'd0, hi_q[31:24]};
        if (is_self) begin
            new_cmd           = '0;
            new_cmd.vector    = wr_data[7:0];
            new_cmd.shorthand = SH_SELF;
        end else begin
            new_cmd = lo_cmd;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start)
                    state_d = (new_cmd.shorthand == SH_NONE) ? ST_RESOLVE : ST_SEND;
            end
            ST_RESOLVE: if (rsv_ack) state_d = ST_SEND;
            ST_SEND:    if (dlv_ready) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q        <= '0;
            wr_err      <= 1'b0;
            rsv_dest    <= '0;
            rsv_logical <= 1'b0;
            dlv_mask    <= '0;
            dlv_vector  <= '0;
            dlv_mode    <= '0;
            dlv_level   <= 1'b0;
            dlv_logical <= 1'b0;
        end else begin
            wr_err <= reject;
            if (acc && is_hi && !ext_mode)
                hi_q <= wr_data[31:0];
            if (start) begin
                rsv_dest    <= new_dest;
                rsv_logical <= new_cmd.logical;
                dlv_mask    <= sh_mask;
                dlv_vector  <= new_cmd.vector;
                dlv_mode    <= new_cmd.dmode;
                dlv_level   <= new_cmd.level;
                dlv_logical <= new_cmd.logical;
            end
            if (state_q == ST_RESOLVE && rsv_ack)
                dlv_mask <= rsv_mask;
        end
    end

    assign wr_ready  = (state_q == ST_IDLE);
    assign rsv_req   = (state_q == ST_RESOLVE);
    assign dlv_valid = (state_q == ST_SEND);

    // checks on the handshakes
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid && !dlv_ready |=> dlv_valid && $stable(dlv_mask) && $stable(dlv_vector));
    assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid || rsv_req) |-> !wr_ready);
    assert_rsv_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_req && !rsv_ack |=> rsv_req && $stable(rsv_dest));
    assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(wr_en));
    assert_one_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsv_req, dlv_valid}));
endmodule

// File: tb/ipi_cmd_issuer_tb_top.sv
module ipi_cmd_issuer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic        clk = 0, rst_n = 0;
    logic        ext_mode = 0;
    logic [7:0]  self_id_leg = 0;
    logic [31:0] self_id_ext = 0;
    logic        wr_en = 0;
    logic [5:0]  wr_idx = 0;
    logic [63:0] wr_data = 0;
    logic        wr_ready, wr_err, rsv_req, rsv_logical, dlv_valid, dlv_level, dlv_logical;
    logic [31:0] rsv_dest;
    logic        rsv_ack = 0, dlv_ready = 0;
    logic [N-1:0] rsv_mask = 0, dlv_mask;
    logic [7:0]  dlv_vector;
    logic [2:0]  dlv_mode;

    int errors = 0, checks = 0, cycles = 0;
    bit done = 0;
    logic [7:0] last_hi = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ipi_cmd_issuer #(.N_UNITS(N), .IDX_W(6)) dut_i (.*);

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] exp_mask(logic [1:0] sh, logic [31:0] sid);
        logic [N-1:0] m = '0;
        for (int i = 0; i < N; i++) begin
            case (sh)
                2'd1: m[i] = (sid == i);
                2'd2: m[i] = 1'b1;
                2'd3: m[i] = (sid != i);
                default: m[i] = 1'b0;
            endcase
        end
        return m;
    endfunction

    task automatic wr(logic [5:0] idx, logic [63:0] d);
        wr_en = 1; wr_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic bad_write(string req, logic [5:0] idx, logic [63:0] d);
        wr(idx, d);
        chk({req, " err pulse"}, wr_err, 1);
        chk({req, " no request"}, {rsv_req, dlv_valid}, 0);
        @(negedge clk);
        chk({req, " err one cycle"}, wr_err, 0);
    endtask

    // drives a send and checks the request; sid is the active self id
    task automatic send(logic [5:0] idx, logic [63:0] d, logic [31:0] dest,
                        logic [31:0] sid, logic [N-1:0] rmask);
        logic [1:0] sh = (idx == 6'h3F) ? 2'd1 : d[19:18];
        logic [N-1:0] em = (sh == 2'd0) ? rmask : exp_mask(sh, sid);
        wr(idx, d);
        chk("R10 no err on legal write", wr_err, 0);
        chk("R11 busy after send", wr_ready, 0);
        if (sh == 2'd0) begin
            chk("R5 resolver asked", rsv_req, 1);
            chk("R3/R4 dest", rsv_dest, dest);
            chk("R3 logical to resolver", rsv_logical, d[11]);
            @(negedge clk);
            chk("R5 resolver waits", rsv_req, 1);
            rsv_ack = 1; rsv_mask = rmask;
            @(negedge clk);
            rsv_ack = 0; rsv_mask = ~rmask;
        end else begin
            chk("R5 no resolver", rsv_req, 0);
        end
        chk("R11 valid", dlv_valid, 1);
        chk("R5/R6/R7 mask", dlv_mask, em);
        if (idx == 6'h3F) begin
            chk("R9 vector", dlv_vector, d[7:0]);
            chk("R9 fixed edge physical", {dlv_mode, dlv_level, dlv_logical}, 0);
        end else begin
            chk("R2 vector", dlv_vector, d[7:0]);
            chk("R2 mode", dlv_mode, d[10:8]);
            chk("R2 level", dlv_level, d[15]);
            chk("R2 logical", dlv_logical, d[11]);
        end
        @(negedge clk);
        chk("R11 held", {dlv_valid, wr_ready}, 2'b10);
        chk("R11 mask stable", dlv_mask, em);
        dlv_ready = 1;
        @(negedge clk);
        dlv_ready = 0;
        chk("R11 released", {dlv_valid, wr_ready}, 2'b01);
    endtask

    initial begin
        logic [31:0] ids [5] = '{0, 3, 7, 8, 32'h103};
        int n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R1 reset", {dlv_valid, rsv_req, wr_err, wr_ready}, 4'b0001);
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                for (int k = 0; k < 5; k++) begin
                    logic [63:0] lo;
                    logic [31:0] sid;
                    logic [31:0] dest;
                    ext_mode = m[0];
                    sid = m ? ids[k] : {24'd0, ids[k][7:0]};
                    self_id_ext = m ? ids[k] : ids[k] + 1;
                    self_id_leg = m ? ids[k][7:0] ^ 8'h01 : ids[k][7:0];
                    lo = (64'(s) << 18) | (64'(n & 1) << 15) | (64'((n >> 1) & 1) << 11)
                       | (64'(n % 8) << 8) | 64'((n * 37 + 5) & 8'hFF);
                    if (m == 0) begin
                        last_hi = 8'(n * 29 + 1);
                        wr(6'h31, {32'd0, last_hi, 24'h00_ABCD});
                        chk("R3 hi write ok", wr_err, 0);
                        dest = {24'd0, last_hi};
                    end else begin
                        dest = 32'h1000_0000 + n;
                        lo[63:32] = dest;
                    end
                    send(6'h30, lo, dest, sid, N'(8'hA5 ^ n));
                    n++;
                end
            end
        end
        // R8: extended hi write rejected, legacy high word kept
        ext_mode = 1;
        bad_write("R8", 6'h31, {32'd0, 8'h77, 24'd0});
        ext_mode = 0; self_id_leg = 2;
        send(6'h30, 64'h0000_0000_0000_0811, {24'd0, last_hi}, 2, 8'h3C);
        // R9 self register
        bad_write("R9 legacy self", 6'h3F, 64'h5A);
        ext_mode = 1; self_id_ext = 5; self_id_leg = 1;
        send(6'h3F, 64'h0000_0000_0001_8F45, 0, 5, 0);
        self_id_ext = 9;
        send(6'h3F, 64'h99, 0, 9, 0);
        // R10 unknown index
        bad_write("R10 unknown", 6'h20, 64'h1234);
        ext_mode = 0;
        bad_write("R10 unknown legacy", 6'h00, 64'h0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule